// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error and Idle Detection

This block turns a start/stop framed serial line into bytes that a processor reads. Line timing comes from a tick at sixteen times the bit rate, generated elsewhere. After the line is resynchronised to the core clock, a framer looks for a falling edge and confirms it at mid-bit. It then samples each data bit three times near the middle of the bit, least significant bit first, and checks the stop bit. When the stop bit has been sampled, the assembled byte moves into a data register that the processor reads.

Status flags record five conditions: a byte waiting, an overrun, noise on a sample, a framing error and an idle line. A flag stays set until the processor reads the status register and then the data register. Two enables route the flags onto one interrupt output: one for received data and one for the idle line. The idle detector arms only after a character has been received with a good stop bit. It disarms each time it reports, so a line that stays high does not report again and again.

The processor read port is a plain strobe with a select and has no back-pressure. A read completes in the cycle it is strobed, and the read data is valid in that same cycle. The serial input has no flow control either. A byte that arrives while the previous one is still unread is dropped and reported as an overrun.

Top module: `async_rx_unit`

## Requirements
- R1: After reset, the status read returns 0, the data read returns 0 and the interrupt output is low.
- R2: A falling edge starts a frame. The start bit must read low by majority at sample ticks 7, 8 and 9 of its 16, or the frame is abandoned. Data bits are taken by the same 7/8/9 majority, least significant bit first. When the stop bit has been sampled, the byte is written to the data register and the full flag is set.
- R3: When the three samples of any start, data or stop bit disagree, the noise flag is set, and the received byte still holds the majority values.
- R4: A stop bit that samples low sets the framing flag, and the byte is still transferred.
- R5: When a character completes while the full flag is still set, the overrun flag is set, the data register keeps the earlier byte and the new byte is discarded.
- R6: All flags are cleared by a status read followed by a data read. A data read without a status read before it clears nothing.
- R7: Status layout (select 0): bit 0 = full, bit 1 = overrun, bit 2 = noise, bit 3 = framing, bit 4 = idle, and the upper bits read 0. Select 1 reads the data register.
- R8: The idle flag is set when the line stays high for 160 ticks (ten bit times) after a character with a good stop bit. It is never set from reset alone, it is not set again until another good character arrives, and a character with a framing error does not arm it.
- R9: While the receiver is disabled, no frames are received and a data read returns 0.
- R10: The interrupt output is high when the receive enable is set and full or overrun is set, or when the idle enable is set and idle is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| rx_irq_en_i | input | 1 | Interrupt enable for full/overrun |
| idle_irq_en_i | input | 1 | Interrupt enable for idle |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | 0 = status, 1 = data |
| rd_data_o | output | 8 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench puts a one-tick glitch in the middle of a chosen bit. A design that trusts a single sample would return a corrupted byte, and one that ignores disagreement would keep the noise flag clear. It sends two bytes back to back with no read between them, which shows whether a design overwrites the unread byte instead of flagging overrun. It also holds the line high from reset, after a good byte and again after a reported idle, and after a character with a bad stop bit, to catch an idle detector that is armed too early or re-arms by itself. It also tries a data read with no status read before it, which a design with a loose clearing sequence would wrongly honour.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_state_e;
  localparam int ST_FULL  = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_NOISE = 2;
  localparam int ST_FRAME = 3;
  localparam int ST_IDLE  = 4;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], din_i};
  end

  assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import async_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 tick_i,
  input  logic                 line_i,
  output logic                 hunting_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 fe_o,
  output logic                 nf_o
);
  localparam int PW  = $clog2(OSR);
  localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int MID = OSR / 2;

  rx_state_e            state_q;
  logic [PW-1:0]        phase_q;
  logic [1:0]           ones_q;
  logic [BW-1:0]        bidx_q;
  logic [DATA_BITS-1:0] shreg_q;
  logic                 nacc_q;

  logic [1:0] total;
  logic       vote, noisy;

  always_comb begin
    total = ones_q + {1'b0, line_i};
    vote  = (total >= 2'd2);
    noisy = (total != 2'd0) && (total != 2'd3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HUNT;
      phase_q <= '0;
      ones_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      nacc_q  <= 1'b0;
      done_o  <= 1'b0;
      byte_o  <= '0;
      fe_o    <= 1'b0;
      nf_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= RX_HUNT;
        phase_q <= '0;
        ones_q  <= '0;
      end else if (tick_i) begin
        if (state_q == RX_HUNT) begin
          if (!line_i) begin
            state_q <= RX_START;
            phase_q <= PW'(1);
            ones_q  <= '0;
            nacc_q  <= 1'b0;
            bidx_q  <= '0;
          end
        end else begin
          phase_q <= (phase_q == PW'(OSR-1)) ? '0 : phase_q + PW'(1);
          if (phase_q == PW'(MID-1) || phase_q == PW'(MID))
            ones_q <= total;
          if (phase_q == PW'(MID+1)) begin
            ones_q <= '0;
            case (state_q)
              RX_START: begin
                if (vote) state_q <= RX_HUNT;
                else      nacc_q  <= nacc_q | noisy;
              end
              RX_DATA: begin
                shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
                nacc_q  <= nacc_q | noisy;
              end
              RX_STOP: begin
                done_o  <= 1'b1;
                byte_o  <= shreg_q;
                fe_o    <= ~vote;
                nf_o    <= nacc_q | noisy;
                state_q <= RX_HUNT;
              end
              default: state_q <= RX_HUNT;
            endcase
          end
          if (phase_q == PW'(OSR-1)) begin
            case (state_q)
              RX_START: begin
                state_q <= RX_DATA;
                bidx_q  <= '0;
              end
              RX_DATA: begin
                if (bidx_q == BW'(DATA_BITS-1)) state_q <= RX_STOP;
                else                            bidx_q  <= bidx_q + BW'(1);
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign hunting_o = (state_q == RX_HUNT);
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
  parameter int IDLE_TICKS = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  input  logic hunting_i,
  input  logic char_ok_i,
  output logic idle_set_o
);
  localparam int CW = $clog2(IDLE_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      idle_set_o <= 1'b0;
    end else begin
      idle_set_o <= 1'b0;
      if (!en_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (char_ok_i) armed_q <= 1'b1;
        if (!hunting_i || !line_i) begin
          cnt_q <= '0;
        end else if (tick_i) begin
          if (cnt_q == CW'(IDLE_TICKS-1)) begin
            cnt_q <= '0;
            if (armed_q) begin
              idle_set_o <= 1'b1;
              armed_q    <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import async_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 char_done_i,
  input  logic [DATA_BITS-1:0] char_byte_i,
  input  logic                 char_fe_i,
  input  logic                 char_nf_i,
  input  logic                 idle_set_i,
  input  logic                 rd_en_i,
  input  logic                 rd_sel_i,
  input  logic                 rx_ie_i,
  input  logic                 idle_ie_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 irq_o,
  output logic                 full_o,
  output logic                 ovr_o,
  output logic                 idle_o,
  output logic [DATA_BITS-1:0] data_o
);
  logic nf_q, fe_q, seen_q, clr;
  logic [DATA_BITS-1:0] stat;

  assign clr = rd_en_i && rd_sel_i && seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      idle_o <= 1'b0;
      nf_q   <= 1'b0;
      fe_q   <= 1'b0;
      seen_q <= 1'b0;
      data_o <= '0;
    end else begin
      if (rd_en_i && !rd_sel_i) seen_q <= 1'b1;
      if (clr) begin
        full_o <= 1'b0;
        ovr_o  <= 1'b0;
        idle_o <= 1'b0;
        nf_q   <= 1'b0;
        fe_q   <= 1'b0;
        seen_q <= 1'b0;
      end
      if (char_done_i) begin
        if (full_o && !clr) begin
          ovr_o <= 1'b1;
        end else begin
          data_o <= char_byte_i;
          full_o <= 1'b1;
          nf_q   <= char_nf_i;
          fe_q   <= char_fe_i;
        end
      end
      if (idle_set_i) idle_o <= 1'b1;
    end
  end

  always_comb begin
    stat           = '0;
    stat[ST_FULL]  = full_o;
    stat[ST_OVR]   = ovr_o;
    stat[ST_NOISE] = nf_q;
    stat[ST_FRAME] = fe_q;
    stat[ST_IDLE]  = idle_o;
    if (rd_sel_i) rd_data_o = en_i ? data_o : '0;
    else          rd_data_o = stat;
  end

  assign irq_o = (rx_ie_i && (full_o || ovr_o)) || (idle_ie_i && idle_o);
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rxd_i,
  input  logic                 tick16_i,
  input  logic                 rx_en_i,
  input  logic                 rx_irq_en_i,
  input  logic                 idle_irq_en_i,
  input  logic                 rd_en_i,
  input  logic                 rd_sel_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 irq_o
);
  localparam int IDLE_TICKS = (DATA_BITS + 2) * OSR;

  logic                 line_s, hunting, char_done, char_fe, char_nf, idle_set;
  logic [DATA_BITS-1:0] char_byte, data_q;
  logic                 full, ovr, idle_flag;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(rxd_i), .dout_o(line_s)
  );

  rx_framer #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .tick_i(tick16_i),
    .line_i(line_s), .hunting_o(hunting), .done_o(char_done),
    .byte_o(char_byte), .fe_o(char_fe), .nf_o(char_nf)
  );

  rx_idle_watch #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .tick_i(tick16_i),
    .line_i(line_s), .hunting_i(hunting), .char_ok_i(char_done && !char_fe),
    .idle_set_o(idle_set)
  );

  rx_regs #(.DATA_BITS(DATA_BITS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i),
    .char_done_i(char_done), .char_byte_i(char_byte), .char_fe_i(char_fe),
    .char_nf_i(char_nf), .idle_set_i(idle_set), .rd_en_i(rd_en_i),
    .rd_sel_i(rd_sel_i), .rx_ie_i(rx_irq_en_i), .idle_ie_i(idle_irq_en_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .full_o(full), .ovr_o(ovr),
    .idle_o(idle_flag), .data_o(data_q)
  );
endmodule

// File: rtl/async_rx_unit_chk.sv
module async_rx_unit_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_en_i,
  input logic                 rx_irq_en_i,
  input logic                 rd_en_i,
  input logic                 rd_sel_i,
  input logic                 irq_o,
  input logic                 line_s,
  input logic                 char_done,
  input logic [DATA_BITS-1:0] char_byte,
  input logic                 full,
  input logic                 ovr,
  input logic                 idle_flag,
  input logic [DATA_BITS-1:0] data_q
);
  a_r2_transfer_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done && !full |=> full && (data_q == $past(char_byte)));

  a_r5_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done && full && !(rd_en_i && rd_sel_i) |=> ovr && $stable(data_q));

  a_r6_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && !(rd_en_i && rd_sel_i) |=> full);

  a_r8_idle_after_high_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_flag) |-> $past(line_s, 2));

  a_r9_disabled_no_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !char_done);

  a_r10_rx_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_en_i && full |-> irq_o);
endmodule

bind async_rx_unit async_rx_unit_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rx_irq_en_i(rx_irq_en_i),
  .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .irq_o(irq_o), .line_s(line_s),
  .char_done(char_done), .char_byte(char_byte), .full(full), .ovr(ovr),
  .idle_flag(idle_flag), .data_q(data_q)
);

// File: tb/test_async_rx_unit.sv
module test_async_rx_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rxd = 1'b1, rx_en = 1'b1, rx_ie = 1'b0, idle_ie = 1'b0;
  logic       rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  logic [1:0] tdiv = 2'd0;
  logic       tick;
  int         checks = 0, failures = 0;
  logic [7:0] v;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  async_rx_unit i_async_rx_unit (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick16_i(tick),
    .rx_en_i(rx_en), .rx_irq_en_i(rx_ie), .idle_irq_en_i(idle_ie),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  // {byte[20:13], glitch_en[12], glitch_bit[11:9], stop_low[8], exp_status[7:0]}
  localparam logic [20:0] VEC [6] = '{
    {8'h55, 1'b0, 3'd0, 1'b0, 8'h01},
    {8'hA3, 1'b1, 3'd3, 1'b0, 8'h05},
    {8'h00, 1'b0, 3'd0, 1'b0, 8'h01},
    {8'hFF, 1'b0, 3'd0, 1'b1, 8'h09},
    {8'h81, 1'b1, 3'd6, 1'b1, 8'h0D},
    {8'h3C, 1'b0, 3'd0, 1'b0, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic gl, input logic [2:0] gbit,
                      input logic stop_low);
    for (int s = 0; s < 10; s++) begin
      logic val;
      val = (s == 0) ? 1'b0 : (s == 9) ? ~stop_low : b[s-1];
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        if (gl && s == gbit + 1 && c >= 31 && c < 35) rxd = ~val;
        else rxd = val;
      end
    end
    @(negedge clk) rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1 d = rd_data;
    @(negedge clk) rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(1'b0, v); check("R1 status", v, 8'h00);
    rd(1'b1, v); check("R1 data", v, 8'h00);
    // R8 no idle from reset
    repeat (800) @(negedge clk);
    rd(1'b0, v); check("R8 no idle from reset", v, 8'h00);
    rd(1'b1, v);

    // R2 R3 R4 R7 table walk
    foreach (VEC[i]) begin
      send(VEC[i][20:13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      rd(1'b0, v); check("R2/R3/R4/R7 status", v, VEC[i][7:0]);
      rd(1'b1, v); check("R2 data", v, VEC[i][20:13]);
    end
    rd(1'b0, v); check("R6 cleared", v, 8'h00);
    rd(1'b1, v);

    // R8 idle after good char, R10 idle irq
    repeat (800) @(negedge clk);
    rd(1'b0, v); check("R8 idle set", v, 8'h10);
    idle_ie = 1'b1;
    @(negedge clk); check("R10 idle irq", {7'd0, irq}, 8'h01);
    rd(1'b1, v);
    @(negedge clk); check("R10 irq clears", {7'd0, irq}, 8'h00);
    repeat (800) @(negedge clk);
    rd(1'b0, v); check("R8 no re-arm", v, 8'h00);
    rd(1'b1, v);
    // R8 framing-error char does not arm
    send(8'h42, 1'b0, 3'd0, 1'b1);
    rd(1'b0, v); rd(1'b1, v);
    repeat (800) @(negedge clk);
    rd(1'b0, v); check("R8 FE no arm", v, 8'h00);
    rd(1'b1, v);
    idle_ie = 1'b0;

    // R5 overrun, R10 rx irq
    rx_ie = 1'b1;
    send(8'h12, 1'b0, 3'd0, 1'b0);
    send(8'h34, 1'b0, 3'd0, 1'b0);
    check("R10 rx irq", {7'd0, irq}, 8'h01);
    rd(1'b0, v); check("R5 status", v, 8'h03);
    rd(1'b1, v); check("R5 data kept", v, 8'h12);
    rd(1'b0, v); check("R5 cleared", v, 8'h00);
    rd(1'b1, v);
    rx_ie = 1'b0;

    // R6 data read without status read does not clear
    send(8'h99, 1'b0, 3'd0, 1'b0);
    rd(1'b1, v); check("R6 data", v, 8'h99);
    rd(1'b0, v); check("R6 not cleared", v, 8'h01);
    rd(1'b1, v);
    rd(1'b0, v); check("R6 cleared after sequence", v, 8'h00);
    rd(1'b1, v);

    // R9 disabled receiver
    rx_en = 1'b0;
    send(8'h77, 1'b0, 3'd0, 1'b0);
    rd(1'b0, v); check("R9 status", v, 8'h00);
    rd(1'b1, v); check("R9 data zero", v, 8'h00);
    rx_en = 1'b1;
    repeat (8) @(negedge clk);
    send(8'h5A, 1'b0, 3'd0, 1'b0);
    rd(1'b0, v); check("R9 re-enabled status", v, 8'h01);
    rd(1'b1, v); check("R9 re-enabled data", v, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule